// File: doc/BRIEF.md
# Per-Pin GPIO Interrupt Detector

This block watches a vector of already-synchronized port pins and turns selected
transitions or levels into pending interrupt flags. Every pin has its own control
word carrying a 4-bit detection mode; each cycle a detector compares the pin with
its own sample from the previous cycle and reports an event when the selected
condition holds.

Events set bits in one shared status word. Software reads the status word to learn
every pending pin in one access, and clears individual pins by writing 1s to the
same word. A single interrupt line summarizes the status word and is asserted while
any flag is pending.

The register port is a simple word bus. Writes complete in the cycle they are
presented. Read data appears one clock after the read strobe.

Top module: `pin_irq_detect`

## Requirements
- R1: After reset all control words read 0, the status word reads 0 and `irq_out` is low.
- R2: Pin n's control word is at byte address 4*n. Its mode field is bits 19:16 and is written from `bus_wdata[19:16]`. All other bits of a control word read as 0.
- R3: Mode 0x9 (rising) sets pin n's flag on the clock edge where the pin is first sampled 1 after being sampled 0. A steady pin or a 1-to-0 change sets nothing.
- R4: Mode 0xA (falling) sets the flag on a 1-to-0 change only.
- R5: Mode 0xB (either) sets the flag on any change of the pin.
- R6: Mode 0x8 (low level) and mode 0xC (high level) set the flag on every clock while the pin holds the selected level. A clear succeeds only after the level has gone.
- R7: The status word is at byte address 0xA0, with bit n belonging to pin n. A write clears each flag whose data bit is 1 and leaves flags whose data bit is 0. Writing all ones clears every flag.
- R8: When a pin's event and a clear of that pin's flag fall in the same cycle, the flag stays set.
- R9: Mode 0x0 and every code not named in R3 to R6 detect nothing. Writing 0 to a control word stops new detection on that pin but keeps a flag that is already pending.
- R10: `irq_out` is the OR of all flags, delayed by one register. It rises one clock after the first flag sets and falls one clock after the last flag clears.
- R11: A read returns its data on `bus_rdata` one clock after the `bus_rd_en` cycle. A status read shows all pending flags together.
- R12: Edge modes compare against a pin history that is kept in every mode. Switching a pin into an edge mode while the pin is steady raises no event.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 8 | Byte address of the access |
| bus_wr_en | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rd_en | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, valid one clock after the strobe |
| pin_in | input | 32 | Synchronized pin levels |
| irq_out | output | 1 | Combined interrupt request |

## Verification
The bench builds the block with its default parameters: 32 pins, an 8-bit address, the status word at 0xA0 and the mode field at bit 16. With these values the highest control word (pin 31 at 0x7C) can be reached, and the status word is a full 32 bits wide, so the all-ones clear covers every flag. A pin-31 level vector checks that the top bit works for both detection and clearing.

// File: rtl/pin_irq_pkg.sv
package pin_irq_pkg;

   localparam int MODE_W = 4;

   typedef enum logic [MODE_W-1:0] {
      MODE_NONE   = 4'h0,
      MODE_LVL_LO = 4'h8,
      MODE_RISE   = 4'h9,
      MODE_FALL   = 4'hA,
      MODE_BOTH   = 4'hB,
      MODE_LVL_HI = 4'hC
   } irq_mode_e;

   function automatic logic is_edge_mode(input logic [MODE_W-1:0] m);
      return (m == MODE_RISE) || (m == MODE_FALL) || (m == MODE_BOTH);
   endfunction

endpackage

// File: rtl/pin_irq_cfg_regs.sv
module pin_irq_cfg_regs
   import pin_irq_pkg::*;
#(
   parameter int NUM_PINS = 32,
   parameter int ADDR_W   = 8
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic [ADDR_W-1:0]              wr_addr,
   input  logic                           wr_en,
   input  logic [MODE_W-1:0]              wr_mode,
   output logic [NUM_PINS-1:0][MODE_W-1:0] mode
);

   localparam int WORD_BYTES = 4;

   initial assert (NUM_PINS * WORD_BYTES <= (1 << ADDR_W))
      else $fatal(1, "pin_irq_cfg_regs: address space too small");

   for (genvar n = 0; n < NUM_PINS; n++) begin : g_pin
      localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(n * WORD_BYTES);
      logic hit;
      assign hit = wr_en && (wr_addr == MY_ADDR);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)   mode[n] <= '0;
         else if (hit) mode[n] <= wr_mode;
      end

      p_cfg_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
         (wr_en && wr_addr == MY_ADDR) |=> (mode[n] == $past(wr_mode)));
      p_cfg_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
         !(wr_en && wr_addr == MY_ADDR) |=> $stable(mode[n]));
   end

endmodule

// File: rtl/pin_irq_event_det.sv
module pin_irq_event_det
   import pin_irq_pkg::*;
#(
   parameter int NUM_PINS = 32
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic [NUM_PINS-1:0]             pin_in,
   input  logic [NUM_PINS-1:0][MODE_W-1:0] mode,
   output logic [NUM_PINS-1:0]             event_o
);

   logic [NUM_PINS-1:0] hist_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) hist_q <= '0;
      else        hist_q <= pin_in;
   end

   for (genvar n = 0; n < NUM_PINS; n++) begin : g_det
      always_comb begin
         unique case (mode[n])
            MODE_LVL_LO: event_o[n] = ~pin_in[n];
            MODE_LVL_HI: event_o[n] =  pin_in[n];
            MODE_RISE:   event_o[n] =  pin_in[n] & ~hist_q[n];
            MODE_FALL:   event_o[n] = ~pin_in[n] &  hist_q[n];
            MODE_BOTH:   event_o[n] =  pin_in[n] ^  hist_q[n];
            default:     event_o[n] = 1'b0;
         endcase
      end

      p_edge_needs_change_r12: assert property (@(posedge clk) disable iff (!rst_n)
         (event_o[n] && is_edge_mode(mode[n])) |-> (pin_in[n] != $past(pin_in[n])));
      p_rise_dir_r3: assert property (@(posedge clk) disable iff (!rst_n)
         (event_o[n] && mode[n] == MODE_RISE) |-> pin_in[n]);
      p_fall_dir_r4: assert property (@(posedge clk) disable iff (!rst_n)
         (event_o[n] && mode[n] == MODE_FALL) |-> !pin_in[n]);
      p_off_silent_r9: assert property (@(posedge clk) disable iff (!rst_n)
         (mode[n] == MODE_NONE) |-> !event_o[n]);
   end

endmodule

// File: rtl/pin_irq_flags.sv
module pin_irq_flags #(
   parameter int NUM_PINS = 32
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_PINS-1:0] event_i,
   input  logic [NUM_PINS-1:0] clr_i,
   output logic [NUM_PINS-1:0] flags,
   output logic                irq
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flags <= '0;
         irq   <= 1'b0;
      end else begin
         flags <= (flags & ~clr_i) | event_i;
         irq   <= |flags;
      end
   end

   p_event_sets_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (flags & $past(event_i)) == $past(event_i));
   p_clear_works_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (flags & $past(clr_i & ~event_i)) == '0);
   p_no_spurious_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ((flags & ~$past(flags)) & ~$past(event_i)) == '0);
   p_irq_follows_r10: assert property (@(posedge clk) disable iff (!rst_n)
      irq == (|$past(flags)));

endmodule

// File: rtl/pin_irq_detect.sv
module pin_irq_detect
   import pin_irq_pkg::*;
#(
   parameter int                NUM_PINS    = 32,
   parameter int                ADDR_W      = 8,
   parameter int                DATA_W      = 32,
   parameter int                MODE_LSB    = 16,
   parameter logic [ADDR_W-1:0] STATUS_ADDR = 8'hA0
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [ADDR_W-1:0]   bus_addr,
   input  logic                bus_wr_en,
   input  logic [DATA_W-1:0]   bus_wdata,
   input  logic                bus_rd_en,
   output logic [DATA_W-1:0]   bus_rdata,
   input  logic [NUM_PINS-1:0] pin_in,
   output logic                irq_out
);

   localparam int CFG_SPAN = NUM_PINS * 4;

   initial assert (NUM_PINS >= 1 && NUM_PINS <= DATA_W)
      else $fatal(1, "pin_irq_detect: NUM_PINS must fit the data word");
   initial assert (MODE_LSB + MODE_W <= DATA_W)
      else $fatal(1, "pin_irq_detect: mode field outside the data word");
   initial assert (int'(STATUS_ADDR) >= CFG_SPAN)
      else $fatal(1, "pin_irq_detect: status word overlaps control words");

   logic [NUM_PINS-1:0][MODE_W-1:0] mode;
   logic [NUM_PINS-1:0]             events;
   logic [NUM_PINS-1:0]             clr;
   logic [NUM_PINS-1:0]             flags;
   logic [DATA_W-1:0]               rd_word;

   pin_irq_cfg_regs #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W)) u_cfg (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_addr (bus_addr),
      .wr_en   (bus_wr_en),
      .wr_mode (bus_wdata[MODE_LSB +: MODE_W]),
      .mode    (mode)
   );

   pin_irq_event_det #(.NUM_PINS(NUM_PINS)) u_det (
      .clk     (clk),
      .rst_n   (rst_n),
      .pin_in  (pin_in),
      .mode    (mode),
      .event_o (events)
   );

   assign clr = (bus_wr_en && bus_addr == STATUS_ADDR) ? bus_wdata[NUM_PINS-1:0] : '0;

   pin_irq_flags #(.NUM_PINS(NUM_PINS)) u_flags (
      .clk     (clk),
      .rst_n   (rst_n),
      .event_i (events),
      .clr_i   (clr),
      .flags   (flags),
      .irq     (irq_out)
   );

   always_comb begin
      rd_word = '0;
      if (bus_addr == STATUS_ADDR) rd_word[NUM_PINS-1:0] = flags;
      for (int n = 0; n < NUM_PINS; n++) begin
         if (bus_addr == ADDR_W'(n * 4)) rd_word[MODE_LSB +: MODE_W] = mode[n];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         bus_rdata <= '0;
      else if (bus_rd_en) bus_rdata <= rd_word;
   end

   p_read_latency_r11: assert property (@(posedge clk) disable iff (!rst_n)
      bus_rd_en |=> (bus_rdata == $past(rd_word)));
   p_read_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_rd_en |=> $stable(bus_rdata));

endmodule

// File: tb/pin_irq_detect_tb_top.sv
module pin_irq_detect_tb_top;

   localparam logic [7:0] STAT = 8'hA0;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic        bus_wr_en = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic        bus_rd_en = 1'b0;
   logic [31:0] bus_rdata;
   logic [31:0] pin_in = '0;
   logic        irq_out;

   int checks = 0;
   int errors = 0;

   always #4 clk = ~clk;

   pin_irq_detect dut_i (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr_en(bus_wr_en),
      .bus_wdata(bus_wdata), .bus_rd_en(bus_rd_en), .bus_rdata(bus_rdata),
      .pin_in(pin_in), .irq_out(irq_out)
   );

   // entry: {mode[11:8], pin[7:3], level before[2], level after[1], flag expected[0]}
   localparam int NV = 15;
   localparam logic [11:0] VEC [NV] = '{
      {4'h9, 5'd3,  1'b0, 1'b1, 1'b1},
      {4'h9, 5'd3,  1'b1, 1'b0, 1'b0},
      {4'h9, 5'd3,  1'b1, 1'b1, 1'b0},
      {4'hA, 5'd7,  1'b1, 1'b0, 1'b1},
      {4'hA, 5'd7,  1'b0, 1'b1, 1'b0},
      {4'hB, 5'd12, 1'b0, 1'b1, 1'b1},
      {4'hB, 5'd12, 1'b1, 1'b0, 1'b1},
      {4'hB, 5'd12, 1'b0, 1'b0, 1'b0},
      {4'h8, 5'd20, 1'b1, 1'b0, 1'b1},
      {4'h8, 5'd20, 1'b1, 1'b1, 1'b0},
      {4'hC, 5'd31, 1'b0, 1'b1, 1'b1},
      {4'hC, 5'd31, 1'b0, 1'b0, 1'b0},
      {4'h0, 5'd5,  1'b0, 1'b1, 1'b0},
      {4'h5, 5'd5,  1'b0, 1'b1, 1'b0},
      {4'hF, 5'd5,  1'b1, 1'b0, 1'b0}
   };

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr_en = 1'b1;
      @(negedge clk);
      bus_wr_en = 1'b0; bus_wdata = '0;
   endtask

   task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_rd_en = 1'b1;
      @(negedge clk);
      bus_rd_en = 1'b0;
      d = bus_rdata;
   endtask

   function automatic string req_of(input logic [3:0] m);
      case (m)
         4'h9: return "R3";
         4'hA: return "R4";
         4'hB: return "R5";
         4'h8, 4'hC: return "R6";
         default: return "R9";
      endcase
   endfunction

   task automatic finish_run();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      logic [31:0] rd;
      tick(3);
      rst_n = 1'b1;
      tick(2);

      // R1: reset state
      check("R1 irq", {31'd0, irq_out}, 32'd0);
      bus_read(STAT, rd);  check("R1 status", rd, 32'd0);
      bus_read(8'h0C, rd); check("R1 control", rd, 32'd0);

      // R2: field position and masking of other bits
      bus_write(8'h24, 32'hFFFF_FFFF);
      bus_read(8'h24, rd); check("R2 readback", rd, 32'h000F_0000);
      bus_read(8'h20, rd); check("R2 neighbour", rd, 32'd0);
      bus_write(8'h24, 32'd0);

      // vector table: R3 R4 R5 R6 R9
      for (int v = 0; v < NV; v++) begin
         logic [3:0] m;
         int idx;
         m = VEC[v][11:8];
         idx = int'(VEC[v][7:3]);
         pin_in[idx] = VEC[v][2];
         bus_write(8'(idx * 4), 32'(m) << 16);
         tick(2);
         bus_write(STAT, 32'hFFFF_FFFF);
         pin_in[idx] = VEC[v][1];
         tick(2);
         bus_read(STAT, rd);
         check(req_of(m), rd, 32'(VEC[v][0]) << idx);
         bus_write(8'(idx * 4), 32'd0);
         pin_in = '0;
         tick(2);
         bus_write(STAT, 32'hFFFF_FFFF);
         tick(2);
      end

      // R10: registered interrupt timing
      bus_write(8'h04, 32'h0009_0000);
      tick(2);
      pin_in[1] = 1'b1;
      @(negedge clk); check("R10 not yet", {31'd0, irq_out}, 32'd0);
      @(negedge clk); check("R10 raised", {31'd0, irq_out}, 32'd1);

      // R7: zero bits leave flags, ones clear them
      bus_write(STAT, 32'hFFFF_FFFD);
      bus_read(STAT, rd); check("R7 zero keeps", rd, 32'h0000_0002);
      bus_write(STAT, 32'h0000_0002);
      check("R10 one clock after clear", {31'd0, irq_out}, 32'd1);
      @(negedge clk); check("R10 dropped", {31'd0, irq_out}, 32'd0);
      bus_read(STAT, rd); check("R7 cleared", rd, 32'd0);

      // R11: two pins pending in one read
      bus_write(8'h08, 32'h0009_0000);
      bus_write(8'h18, 32'h000A_0000);
      pin_in[6] = 1'b1;
      tick(2);
      pin_in[2] = 1'b1; pin_in[6] = 1'b0;
      tick(2);
      bus_read(STAT, rd); check("R11 both pins", rd, 32'h0000_0044);

      // R9: disabling keeps the pending flag, blocks new ones
      bus_write(8'h08, 32'd0);
      bus_write(STAT, 32'h0000_0040);
      pin_in[2] = 1'b0; tick(2); pin_in[2] = 1'b1; tick(2);
      bus_read(STAT, rd); check("R9 flag kept, no new", rd, 32'h0000_0004);
      bus_write(STAT, 32'hFFFF_FFFF);
      bus_write(8'h18, 32'd0);
      bus_write(8'h04, 32'd0);

      // R8 and R6: level high wins over clear, clear works once level gone
      bus_write(8'h10, 32'h000C_0000);
      pin_in[4] = 1'b1;
      tick(2);
      bus_write(STAT, 32'h0000_0010);
      bus_read(STAT, rd); check("R8 event beats clear", rd & 32'h10, 32'h10);
      pin_in[4] = 1'b0;
      tick(1);
      bus_write(STAT, 32'h0000_0010);
      bus_read(STAT, rd); check("R6 clear after level", rd & 32'h10, 32'd0);
      bus_write(8'h10, 32'd0);

      // R12: entering edge mode with a steady high pin raises nothing
      bus_write(STAT, 32'hFFFF_FFFF);
      pin_in[9] = 1'b1;
      tick(3);
      bus_write(8'h24, 32'h000B_0000);
      tick(3);
      bus_read(STAT, rd); check("R12 no event on entry", rd, 32'd0);
      check("R12 irq low", {31'd0, irq_out}, 32'd0);

      finish_run();
   end

endmodule